// File: doc/BRIEF.md
# Direction-Selectable Two-Bit Table-Sequenced Counter

This block is a two-bit cyclic counter whose next value does not come from an adder or a decoder. It comes from a small constant lookup table. The table is indexed by the direction input together with the present count. Every table word carries two things: the successor count, and a one-bit indicator telling whether the present count is zero. A register reloads the successor from the table on each rising clock edge, so the counter steps once per cycle in the chosen direction.

It suits places where a short repeating sequence must be generated and reversed on demand, and where a visible marker is wanted at the zero position. Because the whole behaviour lives in the table, a different sequence needs only new table words and no new logic structure.

Top module: `rom_updown_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 after that edge, and `zero_lamp` is then 1.
- R2: With `dir` = 0 and `rst` low, each rising edge moves the count up by one (0 to 1, 1 to 2, 2 to 3).
- R3: With `dir` = 1 and `rst` low, each rising edge moves the count down by one (3 to 2, 2 to 1, 1 to 0).
- R4: `zero_lamp` is 1 exactly when `count` equals 0, whatever the value of `dir`.
- R5: A change of `dir` takes effect on the first rising edge after it, stepping from the current count in the new direction with no idle cycle.
- R6: The count wraps at the ends: counting up from 3 gives 0, and counting down from 0 gives 3.
- R7: Reset has priority over direction: with `rst` high the count stays 0 for either value of `dir`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Step direction, 0 = up, 1 = down |
| count | output | 2 | Registered count value |
| zero_lamp | output | 1 | High while the count is 0 |

## Verification
A direction reversal and a wraparound can fall in the same cycle. The bench provokes this by raising `dir` at the edge where the count sits at 0, which must give 3, and by lowering it while the count sits at 3, which must give 0. The bench judges each case against a model of the sequence held in the bench, and it also checks the zero indicator in those same cycles. Reset applied under both direction values is judged in the same way, because reset and stepping compete for the same edge.

// File: rtl/rom_updown_counter.sv
module rom_updown_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       dir,
  output logic [1:0] count,
  output logic       zero_lamp
);

  logic [1:0] cnt_q;
  logic [2:0] rom_addr;
  logic [2:0] rom_word;

  assign rom_addr = {dir, cnt_q};

  always_comb begin
    case (rom_addr)
      3'b000:  rom_word = 3'b01_1;
      3'b001:  rom_word = 3'b10_0;
      3'b010:  rom_word = 3'b11_0;
      3'b011:  rom_word = 3'b00_0;
      3'b100:  rom_word = 3'b11_1;
      3'b101:  rom_word = 3'b00_0;
      3'b110:  rom_word = 3'b01_0;
      default: rom_word = 3'b10_0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= 2'd0;
    else     cnt_q <= rom_word[2:1];
  end

  assign count     = cnt_q;
  assign zero_lamp = rom_word[0];

endmodule

module rom_updown_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       dir,
  input logic [1:0] count,
  input logic       zero_lamp
);

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> (count == 2'd0));

  p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!dir) |=> (count == $past(count) + 2'd1));

  p_down_step_r3: assert property (@(posedge clk) disable iff (rst)
    dir |=> (count == $past(count) - 2'd1));

  p_lamp_zero_r4: assert property (@(posedge clk) disable iff (rst)
    zero_lamp == (count == 2'd0));

  p_dir_change_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dir) |=> (count == $past(count) - 2'd1));

  p_wrap_up_r6: assert property (@(posedge clk) disable iff (rst)
    (!dir && count == 2'd3) |=> (count == 2'd0));

  p_wrap_down_r6: assert property (@(posedge clk) disable iff (rst)
    (dir && count == 2'd0) |=> (count == 2'd3));

endmodule

bind rom_updown_counter rom_updown_counter_chk u_chk (
  .clk(clk), .rst(rst), .dir(dir), .count(count), .zero_lamp(zero_lamp)
);

// File: tb/sim_rom_updown_counter.sv
module sim_rom_updown_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir = 1'b0;
  logic [1:0] count;
  logic       zero_lamp;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] exp_cnt = 2'd0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_updown_counter u0 (
    .clk(clk), .rst(rst), .dir(dir), .count(count), .zero_lamp(zero_lamp)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic d, input string tag);
    dir = d;
    @(posedge clk);
    @(negedge clk);
    exp_cnt = d ? exp_cnt - 2'd1 : exp_cnt + 2'd1;
    chk(tag, count, exp_cnt);
    chk("R4 lamp", zero_lamp, exp_cnt == 2'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_cnt = 2'd0;
    chk("R1 count", count, 0);
    chk("R1 lamp", zero_lamp, 1);
  endtask

  task automatic t_up();
    for (int i = 0; i < 6; i++) step(1'b0, "R2 up step / R6 wrap");
  endtask

  task automatic t_down();
    for (int i = 0; i < 6; i++) step(1'b1, "R3 down step / R6 wrap");
  endtask

  task automatic t_switch();
    t_reset();
    step(1'b1, "R5 reverse at zero, R6 wrap to 3");
    chk("R6 down wrap value", count, 3);
    step(1'b0, "R5 reverse at three, R6 wrap to 0");
    chk("R6 up wrap value", count, 0);
    step(1'b0, "R2 up after reversal");
    step(1'b1, "R5 immediate reversal");
    step(1'b0, "R5 immediate reversal back");
    step(1'b1, "R3 down");
  endtask

  task automatic t_reset_priority();
    step(1'b0, "R2 prep");
    step(1'b0, "R2 prep");
    for (int i = 0; i < 2; i++) begin
      rst = 1'b1;
      dir = (i == 1);
      @(posedge clk);
      @(negedge clk);
      chk("R7 reset over dir", count, 0);
      @(posedge clk);
      @(negedge clk);
      chk("R7 reset held", count, 0);
      chk("R7 lamp", zero_lamp, 1);
    end
    rst = 1'b0;
    exp_cnt = 2'd0;
    step(1'b1, "R3 after reset");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_switch();
    t_reset_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule